// File: doc/BRIEF.md
# SPI EEPROM Word Controller

This block is the master side of a serial EEPROM link. The EEPROM is byte addressed and stores 16-bit words. A host issues a request with a direction flag, a starting word offset and a word count. The block checks the request against the device size. For each command it runs a status poll, then moves the words over a mode-0 SPI link. It ends every request with a one-cycle done pulse, and with an error flag when the request failed.

On the pin side the block drives the serial clock, an active-low chip select and the outgoing data line, and it samples the incoming data line. Word offsets become byte addresses by doubling. On parts with an 8-bit address field, the ninth address bit travels inside the opcode. Words cross the link low byte first.

A read is one command followed by a continuous stream of words. A write runs as a series of bursts. Each burst starts with a status poll and a write-enable frame. A burst stops whenever the next byte address falls on a page boundary.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: A request with offset >= WORDS, with count 0, or with count > WORDS - offset raises done_o and err_o together on the clock edge that accepts it. cs_no stays high and no frame is started.
- R2: The address field holds twice the current word offset. It is ADDR_BITS wide, keeps the low ADDR_BITS bits of that value and is sent MSB first after the opcode.
- R3: When ADDR_BITS is 8 and the command's start word offset is 128 or more, the opcode carries bit 3 (0x08) set: the read opcode becomes 0x0B and the write opcode 0x0A. Below offset 128 the opcodes stay 0x03 and 0x02.
- R4: Before each read command and each write burst, the block sends status opcode 0x05 and clocks in 8 bits in the same frame. It repeats this in a new frame until status bit 0 (busy) reads 0.
- R5: If RETRY_MAX status frames in a row return busy, the request ends with done_o and err_o, and no read or write command is sent.
- R6: On the link each word travels with its host low byte first. A word read from byte addresses 2w and 2w+1 appears on rd_data_o as {byte(2w+1), byte(2w)}.
- R7: A read sends the read opcode and address once, then clocks in all count words back to back, with one rd_valid_o pulse per word in address order.
- R8: Each write burst is preceded by a frame holding only opcode 0x06. After it, cs_no goes high, and then comes the write opcode with the burst's start address.
- R9: After each written word, if the next byte address is a multiple of PAGE_BYTES and words remain, the burst ends. The block then polls status, sends write-enable and issues a new write command at the next address.
- R10: SPI mode 0. SCK is low whenever cs_no is high. MOSI changes only on the falling SCK edge and stays constant while SCK is high. MISO is sampled on the rising edge.
- R11: Every accepted request ends with a single-cycle done_o. err_o is only ever high together with done_o.
- R12: SCK stays high for exactly max(sck_half_i,1) clock cycles on every pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_half_i | input | DIV_W | SCK half-period in clocks (0 treated as 1) |
| req_valid_i | input | 1 | Request strobe, taken while busy_o is low |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | HOST_W | Starting word offset |
| req_count_i | input | HOST_W | Number of words |
| wr_data_i | input | 16 | Next word to write, host order |
| wr_take_o | output | 1 | wr_data_i is consumed at this cycle's edge |
| rd_data_o | output | 16 | Read word, host order |
| rd_valid_o | output | 1 | rd_data_o holds a new word |
| done_o | output | 1 | Request finished (pulse) |
| err_o | output | 1 | Request failed (with done_o) |
| busy_o | output | 1 | A request is in progress |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to device |
| miso_i | input | 1 | Serial data from device |

## Verification
A rejected request has a fixed latency. done_o and err_o appear on the accepting edge, so the bench samples them at the very next falling clock edge. Every other result depends on the SCK divider and on how often the device model reports busy, so its cycle is not fixed. Read words are therefore matched by order: a scoreboard queue is filled before the request starts and emptied on each rd_valid_o pulse. Protocol effects are judged from counters in the bench's EEPROM model, after done_o: frames, status reads, write-enables, the opcode flag and the start address. SCK high time is measured cycle by cycle against sck_half_i.

// File: rtl/spi_eeprom_pkg.sv
`timescale 1ns/1ps
package spi_eeprom_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_POLL_OP, S_POLL_RD, S_WREN,
    S_CMD, S_ADDR, S_RDATA, S_WDATA, S_FIN
  } seq_state_e;

  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_HI_ADDR = 8'h08;

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/spi_bit_engine.sv
`timescale 1ns/1ps
module spi_bit_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_i,
  input  logic             start_i,
  input  logic [15:0]      tx_i,
  input  logic [4:0]       nbits_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [15:0]      rx_o
);
  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_state_e;

  eng_state_e       st;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_eff;
  logic [15:0]      sh;
  logic [4:0]       bits;
  logic             last;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign last     = (cnt == half_eff - 1'b1);
  assign mosi_o   = (st != E_IDLE) ? sh[15] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= E_IDLE;
      cnt    <= '0;
      sh     <= '0;
      bits   <= '0;
      sck_o  <= 1'b0;
      done_o <= 1'b0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        E_IDLE: if (start_i) begin
          sh   <= tx_i;
          bits <= nbits_i;
          cnt  <= '0;
          rx_o <= '0;
          st   <= E_LOW;
        end
        E_LOW: if (last) begin
          cnt   <= '0;
          sck_o <= 1'b1;
          rx_o  <= {rx_o[14:0], miso_i};   // sample on rising edge
          st    <= E_HIGH;
        end else begin
          cnt <= cnt + 1'b1;
        end
        E_HIGH: if (last) begin
          cnt   <= '0;
          sck_o <= 1'b0;
          sh    <= {sh[14:0], 1'b0};       // next bit on falling edge
          bits  <= bits - 1'b1;
          if (bits == 5'd1) begin
            st     <= E_IDLE;
            done_o <= 1'b1;
          end else begin
            st <= E_LOW;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_req_check.sv
`timescale 1ns/1ps
module eeprom_req_check #(
  parameter int HOST_W = 16,
  parameter int WORDS  = 256
) (
  input  logic [HOST_W-1:0] offset_i,
  input  logic [HOST_W-1:0] count_i,
  output logic              bad_o
);
  localparam logic [HOST_W:0] LIMIT = (HOST_W+1)'(WORDS);

  logic [HOST_W:0] off_x, cnt_x, room;

  assign off_x = {1'b0, offset_i};
  assign cnt_x = {1'b0, count_i};
  assign room  = LIMIT - off_x;
  assign bad_o = (off_x >= LIMIT) || (count_i == '0) || (cnt_x > room);
endmodule

// File: rtl/eeprom_seq.sv
`timescale 1ns/1ps
module eeprom_seq
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 8,
  parameter int RETRY_MAX  = 8,
  parameter int DIV_W      = 8,
  parameter int HOST_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [HOST_W-1:0] req_offset_i,
  input  logic [HOST_W-1:0] req_count_i,
  input  logic              bad_i,
  input  logic [15:0]       wr_data_i,
  output logic              wr_take_o,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              cs_no,
  output logic              eng_start_o,
  output logic [15:0]       eng_tx_o,
  output logic [4:0]        eng_nbits_o,
  input  logic              eng_done_i,
  input  logic [15:0]       eng_rx_i
);
  localparam int  PW         = $clog2(RETRY_MAX + 1);
  localparam int  PAGE_WORDS = PAGE_BYTES / 2;
  localparam int  PG_W       = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam bit  FOLD_A8    = (ADDR_BITS == 8);
  localparam logic [PW-1:0] LAST_POLL = PW'(RETRY_MAX - 1);

  seq_state_e        st, after_gap;
  logic              launched, is_wr, err_q, cs_q;
  logic [HOST_W-1:0] cur_word, remain;
  logic [PW-1:0]     polls;
  logic [DIV_W-1:0]  gap_cnt, half_eff;
  logic [ADDR_BITS-1:0] addr_field;
  logic [15:0]       tx_addr;
  logic [7:0]        cmd_op;
  logic [PG_W-1:0]   nxt_lo;
  logic              hi_addr, page_end, shifting;

  assign half_eff   = (half_i == '0) ? DIV_W'(1) : half_i;
  assign addr_field = ADDR_BITS'({cur_word, 1'b0});
  assign tx_addr    = 16'(addr_field) << (16 - ADDR_BITS);
  assign hi_addr    = FOLD_A8 && (cur_word >= HOST_W'(128));
  assign cmd_op     = (is_wr ? OP_WRITE : OP_READ) | (hi_addr ? OP_HI_ADDR : 8'h00);
  assign nxt_lo     = cur_word[PG_W-1:0] + 1'b1;
  assign page_end   = (nxt_lo == '0);

  assign shifting    = (st == S_POLL_OP) || (st == S_POLL_RD) || (st == S_WREN) ||
                       (st == S_CMD) || (st == S_ADDR) || (st == S_RDATA) || (st == S_WDATA);
  assign eng_start_o = shifting && !launched;
  assign wr_take_o   = (st == S_WDATA) && !launched;
  assign busy_o      = (st != S_IDLE);
  assign cs_no       = cs_q;

  always_comb begin
    eng_tx_o    = 16'h0000;
    eng_nbits_o = 5'd8;
    case (st)
      S_POLL_OP: eng_tx_o = {OP_RDSR, 8'h00};
      S_WREN:    eng_tx_o = {OP_WREN, 8'h00};
      S_CMD:     eng_tx_o = {cmd_op, 8'h00};
      S_ADDR: begin
        eng_tx_o    = tx_addr;
        eng_nbits_o = 5'(ADDR_BITS);
      end
      S_RDATA:   eng_nbits_o = 5'd16;
      S_WDATA: begin
        eng_tx_o    = swap16(wr_data_i);
        eng_nbits_o = 5'd16;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= S_IDLE;
      after_gap  <= S_IDLE;
      launched   <= 1'b0;
      is_wr      <= 1'b0;
      err_q      <= 1'b0;
      cs_q       <= 1'b1;
      cur_word   <= '0;
      remain     <= '0;
      polls      <= '0;
      gap_cnt    <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      if (eng_start_o) launched <= 1'b1;
      if (eng_done_i)  launched <= 1'b0;
      case (st)
        S_IDLE: if (req_valid_i) begin
          if (bad_i) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            is_wr     <= req_write_i;
            cur_word  <= req_offset_i;
            remain    <= req_count_i;
            polls     <= '0;
            err_q     <= 1'b0;
            after_gap <= S_POLL_OP;
            st        <= S_GAP;
          end
        end
        // chip select held high one half-period between frames
        S_GAP: if (gap_cnt == half_eff - 1'b1) begin
          gap_cnt <= '0;
          cs_q    <= 1'b0;
          st      <= after_gap;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        S_POLL_OP: if (eng_done_i) st <= S_POLL_RD;
        S_POLL_RD: if (eng_done_i) begin
          cs_q <= 1'b1;
          if (eng_rx_i[0]) begin
            if (polls == LAST_POLL) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else begin
              polls     <= polls + 1'b1;
              after_gap <= S_POLL_OP;
              st        <= S_GAP;
            end
          end else begin
            polls     <= '0;
            after_gap <= is_wr ? S_WREN : S_CMD;
            st        <= S_GAP;
          end
        end
        S_WREN: if (eng_done_i) begin
          cs_q      <= 1'b1;
          after_gap <= S_CMD;
          st        <= S_GAP;
        end
        S_CMD:  if (eng_done_i) st <= S_ADDR;
        S_ADDR: if (eng_done_i) st <= is_wr ? S_WDATA : S_RDATA;
        S_RDATA: if (eng_done_i) begin
          rd_data_o  <= swap16(eng_rx_i);
          rd_valid_o <= 1'b1;
          cur_word   <= cur_word + 1'b1;
          remain     <= remain - 1'b1;
          if (remain == HOST_W'(1)) begin
            cs_q <= 1'b1;
            st   <= S_FIN;
          end
        end
        S_WDATA: if (eng_done_i) begin
          cur_word <= cur_word + 1'b1;
          remain   <= remain - 1'b1;
          if (remain == HOST_W'(1)) begin
            cs_q <= 1'b1;
            st   <= S_FIN;
          end else if (page_end) begin
            cs_q      <= 1'b1;
            after_gap <= S_POLL_OP;
            st        <= S_GAP;
          end
        end
        S_FIN: begin
          done_o <= 1'b1;
          err_o  <= err_q;
          err_q  <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl #(
  parameter int ADDR_BITS  = 8,
  parameter int WORDS      = 256,
  parameter int PAGE_BYTES = 8,
  parameter int RETRY_MAX  = 8,
  parameter int DIV_W      = 8,
  parameter int HOST_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  sck_half_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [HOST_W-1:0] req_offset_i,
  input  logic [HOST_W-1:0] req_count_i,
  input  logic [15:0]       wr_data_i,
  output logic              wr_take_o,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic        bad;
  logic        eng_start, eng_done;
  logic [15:0] eng_tx, eng_rx;
  logic [4:0]  eng_nbits;

  eeprom_req_check #(.HOST_W(HOST_W), .WORDS(WORDS)) u_check (
    .offset_i (req_offset_i),
    .count_i  (req_count_i),
    .bad_o    (bad)
  );

  eeprom_seq #(
    .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES), .RETRY_MAX(RETRY_MAX),
    .DIV_W(DIV_W), .HOST_W(HOST_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_i      (sck_half_i),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_offset_i(req_offset_i),
    .req_count_i (req_count_i),
    .bad_i       (bad),
    .wr_data_i   (wr_data_i),
    .wr_take_o   (wr_take_o),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .busy_o      (busy_o),
    .cs_no       (cs_no),
    .eng_start_o (eng_start),
    .eng_tx_o    (eng_tx),
    .eng_nbits_o (eng_nbits),
    .eng_done_i  (eng_done),
    .eng_rx_i    (eng_rx)
  );

  spi_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .half_i  (sck_half_i),
    .start_i (eng_start),
    .tx_i    (eng_tx),
    .nbits_i (eng_nbits),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic done_o,
  input logic err_o,
  input logic busy_o,
  input logic wr_take_o,
  input logic rd_valid_o
);
  p_sck_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  p_mosi_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  p_err_with_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);

  p_take_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> !cs_no);

  p_read_in_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> busy_o);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_no     (cs_no),
  .sck_o     (sck_o),
  .mosi_o    (mosi_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .busy_o    (busy_o),
  .wr_take_o (wr_take_o),
  .rd_valid_o(rd_valid_o)
);

// File: tb/spi_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_tb_top;
  localparam int RETRY_MAX = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sck_half = 8'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_off = '0, req_cnt = '0;
  logic [15:0] wr_data, rd_data;
  logic        wr_take, rd_valid, done, err, busy, sck, cs_n, mosi, miso;

  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(.ADDR_BITS(8), .WORDS(256), .PAGE_BYTES(8), .RETRY_MAX(RETRY_MAX),
                    .DIV_W(8), .HOST_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_half_i(sck_half),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_offset_i(req_off), .req_count_i(req_cnt),
    .wr_data_i(wr_data), .wr_take_o(wr_take),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .done_o(done), .err_o(err), .busy_o(busy),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0] mem [512];
  logic [7:0] m_in, m_out = 8'h00;
  logic [8:0] m_addr;
  logic       m_wel = 0, m_wrote = 0, m_rd = 0, m_a8 = 0, sck_p = 0, cs_p = 1;
  bit         stuck = 0;
  int m_bits = 0, m_phase = 0, busy_left = 0;
  int n_cs = 0, n_wren = 0, n_wrcmd = 0, n_rdcmd = 0, n_rdsr = 0, last_a8 = 0, last_addr = 0;

  assign miso = m_out[7];

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    forever begin
      @(sck or cs_n);
      if (cs_p && !cs_n) begin n_cs++; m_bits = 0; m_phase = 0; end
      if (!cs_p && cs_n && m_wrote) begin m_wel = 0; m_wrote = 0; busy_left = 2; end
      if (!cs_n && !sck_p && sck) begin
        m_in = {m_in[6:0], mosi};
        m_bits++;
        if (m_bits % 8 == 0) begin
          case (m_phase)
            0: begin
              case (m_in)
                8'h06: begin m_wel = 1; n_wren++; m_phase = 5; end
                8'h05: begin
                  n_rdsr++;
                  m_out = {6'b0, m_wel, stuck || (busy_left > 0)};
                  if (busy_left > 0 && !stuck) busy_left--;
                  m_phase = 5;
                end
                8'h03, 8'h0B: begin n_rdcmd++; m_rd = 1; m_a8 = m_in[3]; last_a8 = int'(m_in[3]); m_phase = 1; end
                8'h02, 8'h0A: begin n_wrcmd++; m_rd = 0; m_a8 = m_in[3]; last_a8 = int'(m_in[3]); m_phase = 1; end
                default: m_phase = 5;
              endcase
            end
            1: begin
              m_addr = {m_a8, m_in};
              last_addr = int'(m_addr);
              if (m_rd) begin m_out = mem[m_addr]; m_addr = m_addr + 1'b1; m_phase = 2; end
              else m_phase = 3;
            end
            2: begin m_out = mem[m_addr]; m_addr = m_addr + 1'b1; end
            3: begin
              if (m_wel) begin mem[m_addr] = m_in; m_wrote = 1; end
              m_addr = m_addr + 1'b1;
            end
            default: ;
          endcase
        end
      end else if (!cs_n && sck_p && !sck && (m_bits % 8) != 0) begin
        m_out = {m_out[6:0], 1'b0};
      end
      sck_p = sck;
      cs_p  = cs_n;
    end
  end

  // ---------------- write data feeder ----------------
  logic [15:0] wq [64];
  int take_total = 0;
  assign wr_data = wq[take_total % 64];

  initial forever begin
    @(negedge clk);
    if (wr_take) begin @(posedge clk); #1; take_total++; end
  end

  // ---------------- SCK high-time monitor (R12) ----------------
  int run = 0, run_cnt = 0, run_bad = 0;
  initial forever begin
    @(negedge clk);
    if (sck) run++;
    else if (run > 0) begin
      run_cnt++;
      if (run != ((sck_half == 0) ? 1 : int'(sck_half))) run_bad++;
      run = 0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q [$];
  logic [7:0]  shadow [512];

  initial forever begin
    @(negedge clk);
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected read word", int'(rd_data), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R6 R7 read word", int'(rd_data), int'(e));
      end
    end
  end

  task automatic start_req(input bit wr, input int off, input int cnt);
    @(negedge clk);
    req_write = wr; req_off = 16'(off); req_cnt = 16'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit e);
    int n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    chk(n < 30000, "R11 done reached", n, 0);
    e = err;
    @(negedge clk);
    chk(!done, "R11 done single cycle", int'(done), 0);
  endtask

  task automatic read_words(input int off, input int cnt, output bit e);
    for (int k = 0; k < cnt; k++)
      exp_q.push_back({shadow[2*(off+k)+1], shadow[2*(off+k)]});
    start_req(0, off, cnt);
    wait_done(e);
    chk(exp_q.size() == 0, "R7 all words delivered", exp_q.size(), 0);
  endtask

  task automatic write_words(input int off, input int cnt, input logic [15:0] base, output bit e);
    for (int k = 0; k < cnt; k++) begin
      logic [15:0] w;
      w = base + 16'(k * 16'h0111);
      wq[(take_total + k) % 64] = w;
      shadow[2*(off+k)]   = w[7:0];
      shadow[2*(off+k)+1] = w[15:8];
    end
    start_req(1, off, cnt);
    wait_done(e);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit e;
    int c0, w0, d0, r0, s0, rb0, rc0;
    for (int i = 0; i < 64; i++) wq[i] = '0;
    for (int i = 0; i < 512; i++) shadow[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R10 reset cs high", int'(cs_n), 1);
    chk(sck == 1'b0, "R10 reset sck low", int'(sck), 0);
    chk(done == 1'b0 && err == 1'b0, "R11 reset no done", int'(done), 0);
    chk(busy == 1'b0, "R1 reset idle", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: rejects, result due one edge after acceptance
    c0 = n_cs;
    start_req(0, 256, 1);
    chk(done && err, "R1 offset at size", int'({done, err}), 3);
    start_req(0, 4, 0);
    chk(done && err, "R1 zero count", int'({done, err}), 3);
    start_req(1, 250, 7);
    chk(done && err, "R1 count beyond end", int'({done, err}), 3);
    repeat (10) @(negedge clk);
    chk(n_cs == c0 && cs_n, "R1 no pin activity", n_cs - c0, 0);

    // R2 R3 R6 R7: read below 128
    r0 = n_rdcmd;
    read_words(10, 3, e);
    chk(!e, "R7 read ok", int'(e), 0);
    chk(n_rdcmd - r0 == 1, "R7 single read command", n_rdcmd - r0, 1);
    chk(last_addr == 20, "R2 byte address", last_addr, 20);
    chk(last_a8 == 0, "R3 no flag below 128", last_a8, 0);

    // R3: read at 200 folds bit 8
    read_words(200, 2, e);
    chk(!e, "R3 read ok", int'(e), 0);
    chk(last_a8 == 1, "R3 flag set", last_a8, 1);
    chk(last_addr == 400, "R2 R3 nine-bit address", last_addr, 400);

    // R8 R9: write 6 words from 5, page of 4 words -> two bursts
    w0 = n_wren; d0 = n_wrcmd;
    write_words(5, 6, 16'hA1B2, e);
    chk(!e, "R9 write ok", int'(e), 0);
    chk(n_wren - w0 == 2, "R8 write-enable per burst", n_wren - w0, 2);
    chk(n_wrcmd - d0 == 2, "R9 page split bursts", n_wrcmd - d0, 2);
    chk(last_addr == 16, "R9 second burst address", last_addr, 16);
    chk(mem[10] == 8'hB2 && mem[11] == 8'hA1, "R6 write byte order", int'({mem[11], mem[10]}), 16'hA1B2);

    // R4: device busy for two polls after a write
    s0 = n_rdsr;
    read_words(5, 6, e);
    chk(!e, "R4 readback ok", int'(e), 0);
    chk(n_rdsr - s0 == 3, "R4 poll until ready", n_rdsr - s0, 3);

    // R3: write above 128, single burst
    w0 = n_wren; d0 = n_wrcmd;
    write_words(130, 2, 16'h5C3D, e);
    chk(!e && last_a8 == 1, "R3 write flag", last_a8, 1);
    chk(n_wrcmd - d0 == 1 && n_wren - w0 == 1, "R8 one burst", n_wrcmd - d0, 1);
    read_words(130, 2, e);

    // R5: stuck busy
    stuck = 1; c0 = n_cs; r0 = n_rdcmd;
    start_req(0, 0, 1);
    wait_done(e);
    chk(e, "R5 retry error", int'(e), 1);
    chk(n_cs - c0 == RETRY_MAX, "R5 poll frames", n_cs - c0, RETRY_MAX);
    chk(n_rdcmd == r0, "R5 no command", n_rdcmd - r0, 0);
    stuck = 0;

    // R12: change half period
    sck_half = 8'd3; rb0 = run_bad; rc0 = run_cnt;
    read_words(0, 2, e);
    chk(run_cnt > rc0 && run_bad == rb0, "R12 sck high time 3", run_bad - rb0, 0);
    sck_half = 8'd2;
    read_words(255, 1, e);
    chk(!e, "R1 last word accepted", int'(e), 0);
    chk(run_bad == 0, "R12 sck high time all runs", run_bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule